// File: doc/BRIEF.md
# Codec Serial Port with Mid-Frame Control Slot

This block is a slave-mode synchronous serial port that connects to an audio codec. The codec owns the bit clock (`sio_sck`) and the frame sync (`sio_fs`). The port oversamples these pins with the system clock and only follows them. At every main sync the port shifts one audio word out on `sio_txd` and captures one audio word from `sio_rxd`.

The codec and the port also exchange control words. The host writes a control word, which marks it pending. The port then sets the LSB of the next outgoing audio word to 1. A codec that honours the request pulses sync a second time, half a frame after the main sync. Aligned to that second pulse, the port shifts out the pending control word and captures the codec's control word. If no second pulse comes, the request is repeated in the next frame.

The host sees a small register port with three addresses: 0 for audio, 1 for control and 2 for status. Reads return data one cycle after the read strobe. Frame length and word width are parameters. The defaults are 16-bit words and a 36-bit frame.

Top module: `codec_sio_port`

## Requirements
- R1: After reset, `sio_txd` is 0, and reads of address 2 (status) and address 0 return 0.
- R2: A sync sampled high on a rising `sio_sck` edge (rise k) starts an audio slot. The word written to address 0 goes out MSB first, one bit per rise k+1 .. k+16, launched after the preceding falling edge. When no control word is pending, bit 0 is sent as 0 whatever was written.
- R3: When a control word is pending at rise k, the audio word's bit 0 is sent as 1.
- R4: A sync at rise k+FRAME_BITS/2 in a frame that carried a request opens a control slot. The control word held in the control register at that moment goes out MSB first on the next 16 rises.
- R5: In a granted control slot, the 16 bits on `sio_rxd` are captured into the receive-control register. Status bit 2 then sets and stays set until address 1 is read.
- R6: The 16 bits received in an audio slot are readable at address 0. Status bit 0 sets when the word completes and clears when address 0 is read.
- R7: Writing address 1 sets status bit 1 (control pending). The bit clears once the last control bit has been launched.
- R8: If a request gets no half-frame sync, the control word stays pending and the next audio word carries the request again.
- R9: A half-frame sync in a frame without a request is ignored. No control bits go out, status bit 2 stays 0, and the next audio slot is unaffected.
- R10: With `rx_on_fall` = 1, received bits are sampled on the falling edges that follow rises k+1 .. k+16 instead of on those rises.
- R11: A write to address 1 while a control slot is in progress leaves status bit 1 set. The new word is sent in a later control slot.
- R12: Outside the audio and control slots, `sio_txd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_on_fall | input | 1 | Receive-edge select: 0 rising, 1 falling |
| sio_sck | input | 1 | Bit clock from the codec |
| sio_fs | input | 1 | Frame sync pulse from the codec |
| sio_rxd | input | 1 | Serial data from the codec |
| sio_txd | output | 1 | Serial data to the codec |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select: 0 audio, 1 control, 2 status |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid the cycle after `host_rd` |

## Verification
A wrong frame position counter shows up in two ways: a half-frame sync is rejected, or an extra control slot opens. Either one is visible in the same frame, as a missing or spurious control word on `sio_txd` and as a wrong status bit 2. A stale pending flag shows on the LSB of the very next audio word. Shift counter or edge-select faults corrupt the captured words, which the host read right after each frame exposes.

// File: rtl/codec_sio_pkg.sv
package codec_sio_pkg;
  localparam logic [1:0] HADDR_AUDIO = 2'd0;
  localparam logic [1:0] HADDR_CTRL  = 2'd1;
  localparam logic [1:0] HADDR_STAT  = 2'd2;

  localparam int ST_AUD_RDY  = 0;
  localparam int ST_CTL_PEND = 1;
  localparam int ST_CTL_RDY  = 2;
endpackage

// File: rtl/sio_pin_sync.sv
module sio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic fs,
  input  logic rxd,
  output logic rise_p,
  output logic fall_p,
  output logic fs_q,
  output logic rxd_q
);
  logic [STAGES:0]   sck_r, sck_n;
  logic [STAGES-1:0] fs_r, fs_n;
  logic [STAGES-1:0] rxd_r, rxd_n;

  always_comb begin
    sck_n = (sck_r << 1) | (STAGES+1)'(sck);
    fs_n  = (fs_r  << 1) | STAGES'(fs);
    rxd_n = (rxd_r << 1) | STAGES'(rxd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r <= '0;
      fs_r  <= '0;
      rxd_r <= '0;
    end else begin
      sck_r <= sck_n;
      fs_r  <= fs_n;
      rxd_r <= rxd_n;
    end
  end

  assign rise_p = sck_r[STAGES-1] & ~sck_r[STAGES];
  assign fall_p = ~sck_r[STAGES-1] & sck_r[STAGES];
  assign fs_q   = fs_r[STAGES-1];
  assign rxd_q  = rxd_r[STAGES-1];
endmodule

// File: rtl/sio_frame_ctl.sv
module sio_frame_ctl #(
  parameter int FRAME_BITS = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_p,
  input  logic fs_q,
  input  logic ctl_pend,
  output logic pri_sync,
  output logic sec_sync
);
  localparam int FPW = $clog2(FRAME_BITS);
  localparam int HALF = FRAME_BITS / 2;
  localparam logic [FPW-1:0] HALF_POS = FPW'(HALF - 1);
  localparam logic [FPW-1:0] LAST_POS = FPW'(FRAME_BITS - 1);

  logic [FPW-1:0] fpos, fpos_n;
  logic           req, req_n;

  always_comb begin
    fpos_n   = fpos;
    req_n    = req;
    pri_sync = 1'b0;
    sec_sync = 1'b0;
    if (rise_p) begin
      if (fs_q && fpos == HALF_POS) begin
        fpos_n = fpos + 1'b1;
        if (req) begin
          sec_sync = 1'b1;
          req_n    = 1'b0;
        end
      end else if (fs_q) begin
        fpos_n   = '0;
        pri_sync = 1'b1;
        req_n    = ctl_pend;
      end else if (fpos != LAST_POS) begin
        fpos_n = fpos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpos <= LAST_POS;
      req  <= 1'b0;
    end else begin
      fpos <= fpos_n;
      req  <= req_n;
    end
  end

  // R9
  ign_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p && fs_q && fpos == HALF_POS && !req) |=> (fpos == FPW'(HALF)));

  // R8
  fpos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p && !fs_q && fpos == LAST_POS) |=> (fpos == LAST_POS));
endmodule

// File: rtl/sio_tx_shift.sv
module sio_tx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_p,
  input  logic              load,
  input  logic              load_ctl,
  input  logic [WORD_W-1:0] load_word,
  output logic              txd,
  output logic              ctl_done
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh, sh_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic              is_ctl, is_ctl_n;
  logic              txd_r, txd_n;
  logic              done_r, done_n;

  always_comb begin
    sh_n     = sh;
    cnt_n    = cnt;
    is_ctl_n = is_ctl;
    txd_n    = txd_r;
    done_n   = 1'b0;
    if (load) begin
      sh_n     = load_word;
      cnt_n    = CW'(WORD_W);
      is_ctl_n = load_ctl;
    end else if (fall_p) begin
      if (cnt != '0) begin
        txd_n = sh[WORD_W-1];
        sh_n  = sh << 1;
        cnt_n = cnt - 1'b1;
        if (cnt == CW'(1) && is_ctl) done_n = 1'b1;
      end else begin
        txd_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      is_ctl <= 1'b0;
      txd_r  <= 1'b0;
      done_r <= 1'b0;
    end else begin
      sh     <= sh_n;
      cnt    <= cnt_n;
      is_ctl <= is_ctl_n;
      txd_r  <= txd_n;
      done_r <= done_n;
    end
  end

  assign txd      = txd_r;
  assign ctl_done = done_r;

  // R12
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fall_p) && $past(cnt) == '0 && !$past(load)) |-> !txd_r);
endmodule

// File: rtl/sio_rx_shift.sv
module sio_rx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              rxd_q,
  input  logic              edge_fall,
  input  logic              start,
  input  logic              start_ctl,
  output logic [WORD_W-1:0] word,
  output logic              done_aud,
  output logic              done_ctl
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh, sh_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic              skip, skip_n;
  logic              is_ctl, is_ctl_n;
  logic              da_r, da_n, dc_r, dc_n;
  logic              sample_ev;

  assign sample_ev = edge_fall ? fall_p : rise_p;

  always_comb begin
    sh_n     = sh;
    cnt_n    = cnt;
    skip_n   = skip;
    is_ctl_n = is_ctl;
    da_n     = 1'b0;
    dc_n     = 1'b0;
    if (start) begin
      cnt_n    = CW'(WORD_W);
      skip_n   = edge_fall;
      is_ctl_n = start_ctl;
    end else if (sample_ev && cnt != '0) begin
      if (skip) begin
        skip_n = 1'b0;
      end else begin
        sh_n  = {sh[WORD_W-2:0], rxd_q};
        cnt_n = cnt - 1'b1;
        if (cnt == CW'(1)) begin
          da_n = !is_ctl;
          dc_n = is_ctl;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      skip   <= 1'b0;
      is_ctl <= 1'b0;
      da_r   <= 1'b0;
      dc_r   <= 1'b0;
    end else begin
      sh     <= sh_n;
      cnt    <= cnt_n;
      skip   <= skip_n;
      is_ctl <= is_ctl_n;
      da_r   <= da_n;
      dc_r   <= dc_n;
    end
  end

  assign word     = sh;
  assign done_aud = da_r;
  assign done_ctl = dc_r;

  // R10
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ev && cnt == '0 && !start) |=> $stable(sh));
endmodule

// File: rtl/codec_sio_port.sv
module codec_sio_port
  import codec_sio_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FRAME_BITS  = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on_fall,
  input  logic              sio_sck,
  input  logic              sio_fs,
  input  logic              sio_rxd,
  output logic              sio_txd,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata
);
  // Slots must not overlap: a half frame has to hold a full word plus margin.
  localparam int MIN_FRAME = 2 * WORD_W + 2;
  localparam bit FRAME_OK  = (FRAME_BITS >= MIN_FRAME);

  logic [1:0] rst_pipe;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1] & FRAME_OK;

  logic rise_p, fall_p, fs_q, rxd_q;
  logic pri_sync, sec_sync;
  logic ctl_done;
  logic done_aud, done_ctl;
  logic [WORD_W-1:0] rx_word;

  logic [WORD_W-1:0] aud_tx, aud_tx_n;
  logic [WORD_W-1:0] ctl_tx, ctl_tx_n;
  logic [WORD_W-1:0] aud_rx, aud_rx_n;
  logic [WORD_W-1:0] ctl_rx, ctl_rx_n;
  logic              ctl_pend, ctl_pend_n;
  logic              ctl_dirty, ctl_dirty_n;
  logic              aud_rdy, aud_rdy_n;
  logic              ctl_rdy, ctl_rdy_n;
  logic [WORD_W-1:0] rdata, rdata_n;
  logic [WORD_W-1:0] tx_load_word;
  logic [WORD_W-1:0] status_word;

  sio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .sck    (sio_sck),
    .fs     (sio_fs),
    .rxd    (sio_rxd),
    .rise_p (rise_p),
    .fall_p (fall_p),
    .fs_q   (fs_q),
    .rxd_q  (rxd_q)
  );

  sio_frame_ctl #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_ni),
    .rise_p   (rise_p),
    .fs_q     (fs_q),
    .ctl_pend (ctl_pend),
    .pri_sync (pri_sync),
    .sec_sync (sec_sync)
  );

  assign tx_load_word = sec_sync ? ctl_tx : {aud_tx[WORD_W-1:1], ctl_pend};

  sio_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_ni),
    .fall_p    (fall_p),
    .load      (pri_sync | sec_sync),
    .load_ctl  (sec_sync),
    .load_word (tx_load_word),
    .txd       (sio_txd),
    .ctl_done  (ctl_done)
  );

  sio_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_ni),
    .rise_p    (rise_p),
    .fall_p    (fall_p),
    .rxd_q     (rxd_q),
    .edge_fall (rx_on_fall),
    .start     (pri_sync | sec_sync),
    .start_ctl (sec_sync),
    .word      (rx_word),
    .done_aud  (done_aud),
    .done_ctl  (done_ctl)
  );

  always_comb begin
    status_word              = '0;
    status_word[ST_AUD_RDY]  = aud_rdy;
    status_word[ST_CTL_PEND] = ctl_pend;
    status_word[ST_CTL_RDY]  = ctl_rdy;
  end

  always_comb begin
    aud_tx_n    = aud_tx;
    ctl_tx_n    = ctl_tx;
    aud_rx_n    = aud_rx;
    ctl_rx_n    = ctl_rx;
    ctl_pend_n  = ctl_pend;
    ctl_dirty_n = ctl_dirty;
    aud_rdy_n   = aud_rdy;
    ctl_rdy_n   = ctl_rdy;
    rdata_n     = rdata;

    // control slot bookkeeping, host write applied last so it wins
    if (sec_sync) ctl_dirty_n = 1'b0;
    if (ctl_done) ctl_pend_n  = ctl_dirty_n;
    if (host_wr) begin
      case (host_addr)
        HADDR_AUDIO: aud_tx_n = host_wdata;
        HADDR_CTRL: begin
          ctl_tx_n    = host_wdata;
          ctl_pend_n  = 1'b1;
          ctl_dirty_n = 1'b1;
        end
        default: ;
      endcase
    end

    // host reads clear ready flags, a completing word applied last so it wins
    if (host_rd) begin
      case (host_addr)
        HADDR_AUDIO: begin
          rdata_n   = aud_rx;
          aud_rdy_n = 1'b0;
        end
        HADDR_CTRL: begin
          rdata_n   = ctl_rx;
          ctl_rdy_n = 1'b0;
        end
        HADDR_STAT: rdata_n = status_word;
        default:    rdata_n = '0;
      endcase
    end
    if (done_aud) begin
      aud_rx_n  = rx_word;
      aud_rdy_n = 1'b1;
    end
    if (done_ctl) begin
      ctl_rx_n  = rx_word;
      ctl_rdy_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      aud_tx    <= '0;
      ctl_tx    <= '0;
      aud_rx    <= '0;
      ctl_rx    <= '0;
      ctl_pend  <= 1'b0;
      ctl_dirty <= 1'b0;
      aud_rdy   <= 1'b0;
      ctl_rdy   <= 1'b0;
      rdata     <= '0;
    end else begin
      aud_tx    <= aud_tx_n;
      ctl_tx    <= ctl_tx_n;
      aud_rx    <= aud_rx_n;
      ctl_rx    <= ctl_rx_n;
      ctl_pend  <= ctl_pend_n;
      ctl_dirty <= ctl_dirty_n;
      aud_rdy   <= aud_rdy_n;
      ctl_rdy   <= ctl_rdy_n;
      rdata     <= rdata_n;
    end
  end

  assign host_rdata = rdata;

  // R4
  sec_req_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sec_sync |-> ctl_pend);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_pend && !ctl_done) |=> ctl_pend);

  // R6
  aud_rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (host_rd && host_addr == HADDR_AUDIO && !done_aud) |=> !aud_rdy);

  // R5
  ctl_rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ctl_rdy) |-> $past(done_ctl));
endmodule

// File: tb/tb_codec_sio_port.sv
module tb_codec_sio_port;
  localparam int W  = 16;
  localparam int FB = 36;
  localparam int HF = FB / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, rx_on_fall, sio_sck, sio_fs, sio_rxd, sio_txd;
  logic         host_wr, host_rd;
  logic [1:0]   host_addr;
  logic [W-1:0] host_wdata, host_rdata;

  codec_sio_port #(.WORD_W(W), .FRAME_BITS(FB)) dut (
    .clk(clk), .rst_n(rst_n), .rx_on_fall(rx_on_fall),
    .sio_sck(sio_sck), .sio_fs(sio_fs), .sio_rxd(sio_rxd), .sio_txd(sio_txd),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [W-1:0] m_aud, m_ctl;
  bit           m_pend, fall_mode;
  logic [W-1:0] got_aud, got_ctl, ctl_at_load;
  bit           idle_bad, frame_sec;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (a == 2'd0) m_aud = d;
    if (a == 2'd1) begin m_ctl = d; m_pend = 1'b1; end
  endtask

  task automatic host_read(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic rx_bit(input int r, input bit sec,
                                  input logic [W-1:0] a, input logic [W-1:0] c);
    if (r >= 1 && r <= W) return a[W-r];
    if (sec && r >= HF+1 && r <= HF+W) return c[HF+W-r];
    return 1'b0;
  endfunction

  task automatic do_reset(input bit fall_sel);
    rst_n = 1'b0; rx_on_fall = fall_sel; fall_mode = fall_sel;
    sio_sck = 1'b0; sio_fs = 1'b0; sio_rxd = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = 2'd0; host_wdata = '0;
    m_aud = '0; m_ctl = '0; m_pend = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // codec model: one frame of FB bit periods, sck half period = 8 clocks
  task automatic run_frame(input logic [W-1:0] rx_a, input logic [W-1:0] rx_c,
                           input bit coop, input bit force_sec,
                           input bit mid_wr, input logic [W-1:0] mid_word);
    bit sec;
    sec = 1'b0; got_aud = '0; got_ctl = '0; idle_bad = 1'b0;
    for (int r = 0; r < FB; r++) begin
      @(negedge clk);
      sio_sck = 1'b0;
      if (r == HF) begin
        sec = force_sec || (coop && got_aud[0]);
        ctl_at_load = m_ctl;
      end
      sio_fs = (r == 0) || (r == HF && sec);
      if (!fall_mode) sio_rxd = rx_bit(r, sec, rx_a, rx_c);
      repeat (7) @(negedge clk);
      @(negedge clk);
      if (r >= 1 && r <= W) got_aud[W-r] = sio_txd;
      else if (sec && r >= HF+1 && r <= HF+W) got_ctl[HF+W-r] = sio_txd;
      else if (sio_txd) idle_bad = 1'b1;
      sio_sck = 1'b1;
      if (fall_mode) sio_rxd = rx_bit(r, sec, rx_a, rx_c);
      repeat (7) @(negedge clk);
      if (mid_wr && r == HF + 4) host_write(2'd1, mid_word);
    end
    @(negedge clk);
    sio_sck = 1'b0; sio_fs = 1'b0;
    repeat (12) @(negedge clk);
    frame_sec = sec;
  endtask

  task automatic do_frame(input logic [W-1:0] rx_a, input logic [W-1:0] rx_c,
                          input bit coop, input bit force_sec,
                          input bit mid_wr, input logic [W-1:0] mid_word);
    bit req, granted;
    logic [W-1:0] d;
    logic [W-1:0] exp_aud;
    req = m_pend;
    exp_aud = {m_aud[W-1:1], req};
    run_frame(rx_a, rx_c, coop, force_sec, mid_wr && req, mid_word);
    granted = frame_sec && req;
    if (req) check("R3 audio word carries request", got_aud, exp_aud);
    else     check("R2 audio word MSB first LSB 0", got_aud, exp_aud);
    check("R12 txd idle outside slots", idle_bad, 1'b0);
    if (granted) begin
      check("R4 control word on half-frame slot", got_ctl, ctl_at_load);
      m_pend = mid_wr;
    end else if (frame_sec) begin
      check("R9 no control bits without request", got_ctl, '0);
    end
    host_read(2'd2, d);
    if (granted && mid_wr)   check("R11 pending kept after write in slot", d, {13'b0, granted, m_pend, 1'b1});
    else if (req && !granted) check("R8 pending kept without second sync", d, {13'b0, 1'b0, m_pend, 1'b1});
    else if (frame_sec && !req) check("R9 status after ignored sync", d, {13'b0, 1'b0, m_pend, 1'b1});
    else                      check("R7 status after frame", d, {13'b0, granted, m_pend, 1'b1});
    host_read(2'd0, d);
    if (fall_mode) check("R10 audio rx on falling edge", d, rx_a);
    else           check("R6 audio rx word", d, rx_a);
    if (granted) begin
      host_read(2'd1, d);
      if (fall_mode) check("R10 control rx on falling edge", d, rx_c);
      else           check("R5 control rx word", d, rx_c);
    end
  endtask

  task automatic random_frames(input int n);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] ra, rc, mw;
      bit coop, frc, mid;
      ra = W'($urandom); rc = W'($urandom); mw = W'($urandom);
      if ($urandom_range(0, 2) == 0) host_write(2'd0, W'($urandom));
      if ($urandom_range(0, 2) == 0) host_write(2'd1, W'($urandom));
      coop = ($urandom_range(0, 3) != 0);
      frc  = !m_pend && ($urandom_range(0, 9) == 0);
      mid  = ($urandom_range(0, 6) == 0);
      do_frame(ra, rc, coop, frc, mid, mw);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    int unsigned seed;
    seed = $urandom(32'h00C0DEC5);
    do_reset(1'b0);

    // R1 reset state
    check("R1 txd low after reset", sio_txd, 1'b0);
    host_read(2'd2, d); check("R1 status zero after reset", d, '0);
    host_read(2'd0, d); check("R1 audio rx zero after reset", d, '0);

    // R2 written LSB 1 is forced to 0 without request
    host_write(2'd0, 16'hA5A5);
    do_frame(16'h3C5A, 16'h0, 1'b1, 1'b0, 1'b0, '0);
    host_read(2'd2, d); check("R6 audio ready cleared by read", d, '0);

    // R3 R4 R5 R7 granted control exchange
    host_write(2'd1, 16'h1234);
    host_read(2'd2, d); check("R7 pending set by write", d, 16'h0002);
    do_frame(16'h8001, 16'hC0DE, 1'b1, 1'b0, 1'b0, '0);

    // R8 refused, then granted on retry
    host_write(2'd1, 16'hBEEF);
    do_frame(16'h7FFE, 16'h5555, 1'b0, 1'b0, 1'b0, '0);
    do_frame(16'h0F0F, 16'hAAAA, 1'b1, 1'b0, 1'b0, '0);

    // R9 half-frame sync without request
    do_frame(16'hFFFF, 16'h9999, 1'b0, 1'b1, 1'b0, '0);
    do_frame(16'h1111, 16'h0, 1'b1, 1'b0, 1'b0, '0);

    // R11 write during control slot, then new word goes out
    host_write(2'd1, 16'h4321);
    do_frame(16'h2222, 16'h3333, 1'b1, 1'b0, 1'b1, 16'hFACE);
    do_frame(16'h4444, 16'h6666, 1'b1, 1'b0, 1'b0, '0);

    random_frames(24);

    // R10 falling-edge receive
    do_reset(1'b1);
    host_write(2'd1, 16'h0BAD);
    do_frame(16'hE00F, 16'h7007, 1'b1, 1'b0, 1'b0, '0);
    random_frames(8);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule